// File: doc/BRIEF.md
# In-Order Commit Reorder Ring

This block sits between decode and the architectural register file. Decode claims a slot at the young end of a circular buffer and receives that slot's tag. Execution units may finish in any order. Each unit writes its result, and a fault flag, back into the slot named by the tag. The block only lets results leave from the old end of the buffer. This keeps the architectural state in program order, so exceptions are precise.

When the oldest slot holds a finished result without a fault, the block presents the destination register and value for one cycle and frees the slot. When the oldest finished slot carries a fault, nothing is committed. The block raises a trap strobe and empties the whole buffer, so that fetch can be redirected to a handler. A tag-indexed read port lets a later instruction pick up a result that is finished but not yet committed.

Top module: `commit_ring`

## Requirements
- R1: After reset the ring is empty: `level` is 0, `alloc_ok` is 1, `alloc_tag` is 0, and `commit_valid` and `trap_flush` are 0.
- R2: Each accepted allocation takes the slot whose tag is on `alloc_tag` in that cycle. Tags are handed out in ascending order and wrap from DEPTH-1 back to 0. `level` rises by one for each accepted allocation.
- R3: When `level` equals DEPTH, `alloc_ok` is 0 and an allocation request changes nothing.
- R4: A writeback stores its value in the slot named by `wb_tag` and marks that slot finished. From the next cycle, `peek_hit` is 1 for that tag and `peek_data` shows the value. For a slot that is not finished, `peek_hit` is 0.
- R5: Only the oldest slot can commit, and only once it is finished. A younger finished slot waits behind an unfinished older one, and an empty ring commits nothing.
- R6: A commit shows `commit_valid`=1 together with the slot's destination register and value for exactly one cycle. That slot is then freed, and `level` falls by one.
- R7: When the oldest slot is finished with its fault flag set, `trap_flush` is 1 for one cycle, `commit_valid` stays 0 and `alloc_ok` is 0. On the next cycle the ring is empty, `alloc_tag` is back to 0, and no slot that was younger than the faulting one has committed or reads as finished.
- R8: An allocation and a commit in the same cycle both take effect, and `level` stays the same.
- R9: A writeback to a slot that is not allocated, or one made in a trap cycle, is ignored. Afterwards `level`, `commit_valid` and `peek_hit` for that tag are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Decode asks for a slot |
| alloc_reg | input | REG_W | Destination register of the new instruction |
| alloc_ok | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | log2(DEPTH) | Tag of the slot taken this cycle |
| wb_valid | input | 1 | Execution-unit result is present |
| wb_tag | input | log2(DEPTH) | Slot the result belongs to |
| wb_data | input | DATA_W | Result value |
| wb_fault | input | 1 | Result raised an exception |
| peek_tag | input | log2(DEPTH) | Slot to read for forwarding |
| peek_hit | output | 1 | The read slot is allocated and finished |
| peek_data | output | DATA_W | Value held in the read slot |
| commit_valid | output | 1 | Register-file write strobe |
| commit_reg | output | REG_W | Register to write |
| commit_data | output | DATA_W | Value to write |
| trap_flush | output | 1 | Faulting instruction reached the old end; the ring is flushed |
| level | output | log2(DEPTH+1) | Occupied slot count |

## Verification
The main pattern is finishing in reverse order: three slots complete youngest first. This separates strict head-only commit from a design that commits any finished slot. An allocation is then overlapped with a commit to show that the count update handles both in one cycle. A fill from a non-zero tail separates correct tag wrap and full detection from off-by-one pointer logic. A faulting head with a finished younger slot behind it shows that the flush discards younger work instead of committing it.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef enum logic [1:0] {
    HEAD_WAIT   = 2'd0,
    HEAD_COMMIT = 2'd1,
    HEAD_TRAP   = 2'd2
  } head_act_e;
endpackage

// File: rtl/head_judge.sv
module head_judge
  import ring_pkg::*;
(
  input  logic      empty,
  input  logic      h_valid,
  input  logic      h_done,
  input  logic      h_fault,
  output head_act_e act
);
  always_comb begin
    act = HEAD_WAIT;
    if (!empty && h_valid && h_done) begin
      act = h_fault ? HEAD_TRAP : HEAD_COMMIT;
    end
  end
endmodule

// File: rtl/ring_ptrs.sv
module ring_ptrs #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_fire,
  input  logic          retire,
  input  logic          flush,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [PW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (flush) begin
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end else begin
      if (alloc_fire) tail_d = bump(tail_q);
      if (retire)     head_d = bump(head_q);
      case ({alloc_fire, retire})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_full_blocks_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_fire);
  assert_empty_no_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !retire);
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0 && head_q == '0 && tail_q == '0));
  assert_alloc_and_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && retire && !flush) |=> $stable(cnt_q));
endmodule

// File: rtl/ring_slots.sv
module ring_slots #(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_fire,
  input  logic [PW-1:0]     alloc_idx,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic              wb_en,
  input  logic [PW-1:0]     wb_idx,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              wb_fault,
  input  logic              retire,
  input  logic              flush,
  input  logic [PW-1:0]     head_idx,
  input  logic [PW-1:0]     peek_idx,
  output logic              h_valid,
  output logic              h_done,
  output logic              h_fault,
  output logic [REG_W-1:0]  h_reg,
  output logic [DATA_W-1:0] h_data,
  output logic              peek_hit,
  output logic [DATA_W-1:0] peek_data
);
  typedef struct packed {
    logic              valid;
    logic              done;
    logic              fault;
    logic [REG_W-1:0]  dst;
    logic [DATA_W-1:0] val;
  } slot_t;

  slot_t slot_q [DEPTH];
  slot_t slot_d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_comb begin
      slot_d[i] = slot_q[i];
      if (flush) begin
        slot_d[i].valid = 1'b0;
        slot_d[i].done  = 1'b0;
      end else begin
        if (retire && head_idx == PW'(i)) begin
          slot_d[i].valid = 1'b0;
          slot_d[i].done  = 1'b0;
        end
        if (alloc_fire && alloc_idx == PW'(i)) begin
          slot_d[i].valid = 1'b1;
          slot_d[i].done  = 1'b0;
          slot_d[i].fault = 1'b0;
          slot_d[i].dst   = alloc_reg;
        end
        if (wb_en && wb_idx == PW'(i) && slot_q[i].valid) begin
          slot_d[i].done  = 1'b1;
          slot_d[i].fault = wb_fault;
          slot_d[i].val   = wb_data;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[i] <= '0;
      else        slot_q[i] <= slot_d[i];
    end
  end

  assign h_valid   = slot_q[head_idx].valid;
  assign h_done    = slot_q[head_idx].done;
  assign h_fault   = slot_q[head_idx].fault;
  assign h_reg     = slot_q[head_idx].dst;
  assign h_data    = slot_q[head_idx].val;
  assign peek_hit  = slot_q[peek_idx].valid && slot_q[peek_idx].done;
  assign peek_data = slot_q[peek_idx].val;

  assert_alloc_free_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> !slot_q[alloc_idx].valid);
  assert_retire_done_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> (slot_q[head_idx].valid && slot_q[head_idx].done));
endmodule

// File: rtl/commit_ring.sv
module commit_ring
  import ring_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_req,
  input  logic [REG_W-1:0]             alloc_reg,
  output logic                         alloc_ok,
  output logic [$clog2(DEPTH)-1:0]     alloc_tag,
  input  logic                         wb_valid,
  input  logic [$clog2(DEPTH)-1:0]     wb_tag,
  input  logic [DATA_W-1:0]            wb_data,
  input  logic                         wb_fault,
  input  logic [$clog2(DEPTH)-1:0]     peek_tag,
  output logic                         peek_hit,
  output logic [DATA_W-1:0]            peek_data,
  output logic                         commit_valid,
  output logic [REG_W-1:0]             commit_reg,
  output logic [DATA_W-1:0]            commit_data,
  output logic                         trap_flush,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;
  logic full, empty;
  logic h_valid, h_done, h_fault;
  logic [REG_W-1:0]  h_reg;
  logic [DATA_W-1:0] h_data;
  head_act_e act;
  logic retire, flush, alloc_fire, wb_en;

  assign retire     = (act == HEAD_COMMIT);
  assign flush      = (act == HEAD_TRAP);
  assign alloc_ok   = !full && !flush;
  assign alloc_fire = alloc_req && alloc_ok;
  assign wb_en      = wb_valid && !flush;

  ring_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .retire(retire),
    .flush(flush), .head(head), .tail(tail), .count(count),
    .full(full), .empty(empty)
  );

  ring_slots #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .alloc_idx(tail),
    .alloc_reg(alloc_reg), .wb_en(wb_en), .wb_idx(wb_tag), .wb_data(wb_data),
    .wb_fault(wb_fault), .retire(retire), .flush(flush), .head_idx(head),
    .peek_idx(peek_tag), .h_valid(h_valid), .h_done(h_done),
    .h_fault(h_fault), .h_reg(h_reg), .h_data(h_data),
    .peek_hit(peek_hit), .peek_data(peek_data)
  );

  head_judge u_judge (
    .empty(empty), .h_valid(h_valid), .h_done(h_done),
    .h_fault(h_fault), .act(act)
  );

  assign alloc_tag    = tail;
  assign commit_valid = retire;
  assign commit_reg   = h_reg;
  assign commit_data  = h_data;
  assign trap_flush   = flush;
  assign level        = count;

  assert_commit_frees_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !alloc_fire) |=> (level == $past(level) - CW'(1)));
  assert_trap_blocks_alloc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_flush |-> (!alloc_ok && !commit_valid));
endmodule

// File: tb/sim_commit_ring.sv
module sim_commit_ring;
  localparam int DEPTH = 8, REG_W = 5, DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic alloc_req;
  logic [REG_W-1:0] alloc_reg;
  logic alloc_ok;
  logic [2:0] alloc_tag;
  logic wb_valid;
  logic [2:0] wb_tag;
  logic [DATA_W-1:0] wb_data;
  logic wb_fault;
  logic [2:0] peek_tag;
  logic peek_hit;
  logic [DATA_W-1:0] peek_data;
  logic commit_valid;
  logic [REG_W-1:0] commit_reg;
  logic [DATA_W-1:0] commit_data;
  logic trap_flush;
  logic [3:0] level;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  commit_ring #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_reg(alloc_reg),
    .alloc_ok(alloc_ok), .alloc_tag(alloc_tag), .wb_valid(wb_valid),
    .wb_tag(wb_tag), .wb_data(wb_data), .wb_fault(wb_fault),
    .peek_tag(peek_tag), .peek_hit(peek_hit), .peek_data(peek_data),
    .commit_valid(commit_valid), .commit_reg(commit_reg),
    .commit_data(commit_data), .trap_flush(trap_flush), .level(level)
  );

  // {alloc, dst[5], wbv, wbtag[3], wbdat[8], wbfault, exp_commit, exp_reg[5], exp_dat[8], exp_tag[3], exp_lvl[4]}
  localparam logic [39:0] VEC [12] = '{
    {1'b1,5'd3,1'b0,3'd0,8'h00,1'b0, 1'b0,5'd0,8'h00,3'd0,4'd0},
    {1'b1,5'd4,1'b0,3'd0,8'h00,1'b0, 1'b0,5'd0,8'h00,3'd1,4'd1},
    {1'b1,5'd5,1'b0,3'd0,8'h00,1'b0, 1'b0,5'd0,8'h00,3'd2,4'd2},
    {1'b0,5'd0,1'b1,3'd1,8'h11,1'b0, 1'b0,5'd0,8'h00,3'd3,4'd3},
    {1'b0,5'd0,1'b1,3'd2,8'h22,1'b0, 1'b0,5'd0,8'h00,3'd3,4'd3},
    {1'b0,5'd0,1'b1,3'd0,8'h33,1'b0, 1'b0,5'd0,8'h00,3'd3,4'd3},
    {1'b0,5'd0,1'b0,3'd0,8'h00,1'b0, 1'b1,5'd3,8'h33,3'd3,4'd3},
    {1'b1,5'd6,1'b0,3'd0,8'h00,1'b0, 1'b1,5'd4,8'h11,3'd3,4'd2},
    {1'b0,5'd0,1'b0,3'd0,8'h00,1'b0, 1'b1,5'd5,8'h22,3'd4,4'd2},
    {1'b0,5'd0,1'b1,3'd3,8'h44,1'b0, 1'b0,5'd0,8'h00,3'd4,4'd1},
    {1'b0,5'd0,1'b0,3'd0,8'h00,1'b0, 1'b1,5'd6,8'h44,3'd4,4'd1},
    {1'b0,5'd0,1'b0,3'd0,8'h00,1'b0, 1'b0,5'd0,8'h00,3'd4,4'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_in();
    alloc_req = 1'b0; alloc_reg = '0; wb_valid = 1'b0; wb_tag = '0;
    wb_data = '0; wb_fault = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle_in();
    peek_tag = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 level", 32'(level), 0);
    chk("R1 alloc_ok", 32'(alloc_ok), 1);
    chk("R1 alloc_tag", 32'(alloc_tag), 0);
    chk("R1 commit_valid", 32'(commit_valid), 0);
    chk("R1 trap_flush", 32'(trap_flush), 0);

    // Reverse-order finishing, in-order commit, overlapped alloc+commit: R5, R6, R8
    for (int v = 0; v < 12; v++) begin
      alloc_req = VEC[v][39];
      alloc_reg = VEC[v][38:34];
      wb_valid  = VEC[v][33];
      wb_tag    = VEC[v][32:30];
      wb_data   = 32'(VEC[v][29:22]);
      wb_fault  = VEC[v][21];
      #1;
      chk("R5 commit_valid", 32'(commit_valid), 32'(VEC[v][20]));
      if (VEC[v][20]) begin
        chk("R6 commit_reg", 32'(commit_reg), 32'(VEC[v][19:15]));
        chk("R6 commit_data", commit_data, 32'(VEC[v][14:7]));
      end
      chk("R2 alloc_tag", 32'(alloc_tag), 32'(VEC[v][6:4]));
      chk("R8 level", 32'(level), 32'(VEC[v][3:0]));
      tick();
    end
    idle_in();

    // R2 tag wrap while filling from tag 4
    for (int k = 0; k < DEPTH; k++) begin
      alloc_req = 1'b1;
      alloc_reg = 5'(k + 8);
      #1;
      chk("R2 wrap tag", 32'(alloc_tag), 32'((4 + k) % DEPTH));
      chk("R2 alloc_ok", 32'(alloc_ok), 1);
      tick();
    end
    chk("R3 full level", 32'(level), DEPTH);
    chk("R3 alloc_ok low", 32'(alloc_ok), 0);
    tick();
    chk("R3 alloc ignored", 32'(level), DEPTH);
    idle_in();

    // R4 forwarding read
    wb_valid = 1'b1; wb_tag = 3'd6; wb_data = 32'hAB;
    tick();
    idle_in();
    peek_tag = 3'd6;
    #1;
    chk("R4 peek_hit", 32'(peek_hit), 1);
    chk("R4 peek_data", peek_data, 32'hAB);
    peek_tag = 3'd5;
    #1;
    chk("R4 peek_hit unfinished", 32'(peek_hit), 0);
    chk("R5 younger waits", 32'(commit_valid), 0);

    // R7 fault at the head (tag 4), younger tag 6 already finished
    wb_valid = 1'b1; wb_tag = 3'd4; wb_data = 32'h55; wb_fault = 1'b1;
    tick();
    idle_in();
    alloc_req = 1'b1; alloc_reg = 5'd9;
    wb_valid = 1'b1; wb_tag = 3'd7; wb_data = 32'h66;
    #1;
    chk("R7 trap_flush", 32'(trap_flush), 1);
    chk("R7 no commit", 32'(commit_valid), 0);
    chk("R7 alloc_ok low", 32'(alloc_ok), 0);
    tick();
    idle_in();
    peek_tag = 3'd6;
    #1;
    chk("R7 level", 32'(level), 0);
    chk("R7 tag restart", 32'(alloc_tag), 0);
    chk("R7 trap one cycle", 32'(trap_flush), 0);
    chk("R7 younger discarded", 32'(peek_hit), 0);
    peek_tag = 3'd7;
    #1;
    chk("R9 trap-cycle writeback", 32'(peek_hit), 0);

    // R9 writeback to an unallocated slot
    wb_valid = 1'b1; wb_tag = 3'd2; wb_data = 32'h99;
    tick();
    idle_in();
    peek_tag = 3'd2;
    #1;
    chk("R9 level", 32'(level), 0);
    chk("R9 peek_hit", 32'(peek_hit), 0);
    chk("R9 commit_valid", 32'(commit_valid), 0);

    // R6 single commit after recovery
    alloc_req = 1'b1; alloc_reg = 5'd17;
    tick();
    idle_in();
    peek_tag = 3'd0;
    #1;
    chk("R4 fresh slot unfinished", 32'(peek_hit), 0);
    wb_valid = 1'b1; wb_tag = 3'd0; wb_data = 32'h77;
    tick();
    idle_in();
    chk("R6 commit_valid", 32'(commit_valid), 1);
    chk("R6 commit_reg", 32'(commit_reg), 17);
    chk("R6 commit_data", commit_data, 32'h77);
    tick();
    chk("R6 one cycle", 32'(commit_valid), 0);
    chk("R6 level", 32'(level), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule